// File: doc/BRIEF.md
# SD Command Frame Serializer

This block turns a set of command fields into a complete 48-bit SD/SDIO command frame. It shifts the frame out on the single command line, one bit per SD clock. A host presents the fields and pulses `start`. The block latches the fields and waits for the pacing strobe `bit_tick`. That strobe marks each falling edge of the SD clock. On every strobe the block drives the next bit, most significant first, so the card can sample it on the rising edge.

The block supports two argument sources. In packed mode it builds the 32-bit argument of the single-byte I/O register command from separate fields, and it forces the command index to 52. In raw mode it sends any command index with a 32-bit argument given by the host unchanged. In both modes it computes the 7-bit CRC bit-serially while the first 40 bits go out. After the CRC it appends the end bit, then releases the line and pulses `done`.

Top module: `sd_cmd_serializer`

## Requirements
- R1: After reset, `cmd_out` is 1, `cmd_oe` is 0, and `busy` and `done` are 0.
- R2: A frame is 48 bits, sent most significant bit first. Frame bit 47 is a start bit of 0. Bit 46 is the direction bit, 1 for host-to-card. Bits 45:40 are the command index. Bits 39:8 are the 32-bit argument. Bits 7:1 are the CRC. Bit 0 is an end bit of 1.
- R3: With `raw_mode` at 0, the index is 52 and the argument is packed as follows. Bit 31 is `wr_flag` (1 = write). Bits 30:28 are `func_num`. Bit 27 is `rdback_flag`. Bit 26 is 0. Bits 25:9 are `reg_addr`. Bit 8 is 0. Bits 7:0 are `wr_data`.
- R4: With `raw_mode` at 1, the index is `cmd_index` and the argument is `raw_arg`, both sent unchanged.
- R5: The CRC uses the generator x^7 + x^3 + 1. It starts from zero for each frame and covers frame bits 47:8. For an index of 0 with an all-zero argument, the last byte of the frame is 0x95.
- R6: The first frame bit appears at the first `bit_tick` after `start` is accepted. Each later `bit_tick` advances exactly one bit. `cmd_out` and `cmd_oe` change only on a `bit_tick`.
- R7: `cmd_oe` is 1 for exactly the 48 bit times of the frame. At all other times the line is released, with `cmd_oe` at 0 and `cmd_out` at 1.
- R8: At the `bit_tick` after the end bit, `done` goes to 1 for exactly one clock cycle, and `busy` returns to 0 in that same cycle.
- R9: A `start` pulse while `busy` is 1 is ignored. The frame in progress continues unchanged and ends on its normal tick.
- R10: All fields are captured when `start` is accepted. Changes to the field inputs during a frame do not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to send a frame, accepted when idle |
| raw_mode | input | 1 | 1 = raw index and argument, 0 = packed register command |
| cmd_index | input | 6 | Command index used in raw mode |
| raw_arg | input | 32 | Argument used in raw mode |
| wr_flag | input | 1 | Packed mode: 1 = write, 0 = read |
| func_num | input | 3 | Packed mode: function number |
| rdback_flag | input | 1 | Packed mode: read-after-write flag |
| reg_addr | input | 17 | Packed mode: register address |
| wr_data | input | 8 | Packed mode: data byte |
| bit_tick | input | 1 | One-cycle strobe at each SD clock falling edge |
| cmd_out | output | 1 | Command line output value |
| cmd_oe | output | 1 | Command line output enable |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse when the frame has finished |

## Verification
The bench rebuilds each expected 48-bit frame, including its CRC, and compares it bit by bit. The CRC is anchored by the known trailing byte 0x95 for an all-zero index 0 frame. A CRC that was not cleared between frames, or that kept folding in bits during its own output, would show up on back-to-back random frames. Field-order errors in the packed register command would land bits in the wrong positions. The bench drives `start` pulses and field changes in the middle of frames. A design that restarted, or that re-read its inputs, would send a corrupted frame or finish on the wrong tick. The bench also watches the gaps between strobes and both edges of the enable window. This catches a line that moves without a strobe, a window that is one bit short or long, or a `done` pulse that lasts more than one cycle.

// File: rtl/sd_cmd_serializer.sv
module sd_cmd_serializer #(
  parameter int IDX_W  = 6,
  parameter int ARG_W  = 32,
  parameter int FUNC_W = 3,
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int CRC_W  = 7,
  parameter logic [CRC_W-1:0] CRC_POLY = 7'h09,
  parameter logic [IDX_W-1:0] REG_CMD_IDX = 6'd52
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              raw_mode,
  input  logic [IDX_W-1:0]  cmd_index,
  input  logic [ARG_W-1:0]  raw_arg,
  input  logic              wr_flag,
  input  logic [FUNC_W-1:0] func_num,
  input  logic              rdback_flag,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              bit_tick,
  output logic              cmd_out,
  output logic              cmd_oe,
  output logic              busy,
  output logic              done
);
  localparam int HDR_W   = 2 + IDX_W + ARG_W;
  localparam int FRAME_W = HDR_W + CRC_W + 1;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int CSEL_W  = $clog2(CRC_W);
  localparam logic [CNT_W-1:0] HDR_END = CNT_W'(HDR_W);
  localparam logic [CNT_W-1:0] CRC_END = CNT_W'(HDR_W + CRC_W);
  localparam logic [CNT_W-1:0] CRC_TOP = CNT_W'(HDR_W + CRC_W - 1);

  logic [HDR_W-1:0] sh_q;
  logic [CRC_W-1:0] crc_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q, out_q, oe_q;

  wire [ARG_W-1:0] packed_arg = {wr_flag, func_num, rdback_flag, 1'b0,
                                 reg_addr, 1'b0, wr_data};
  wire [HDR_W-1:0] hdr = {1'b0, 1'b1,
                          raw_mode ? cmd_index : REG_CMD_IDX,
                          raw_mode ? raw_arg   : packed_arg};

  wire             fb       = crc_q[CRC_W-1] ^ sh_q[HDR_W-1];
  wire [CRC_W-1:0] crc_next = {crc_q[CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & CRC_POLY);
  wire [CNT_W-1:0] crc_pos  = CRC_TOP - cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      crc_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      out_q  <= 1'b1;
      oe_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q && start) begin
        sh_q   <= hdr;
        crc_q  <= '0;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q && bit_tick) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q < HDR_END) begin
          out_q <= sh_q[HDR_W-1];
          oe_q  <= 1'b1;
          sh_q  <= sh_q << 1;
          crc_q <= crc_next;
        end else if (cnt_q < CRC_END) begin
          out_q <= crc_q[crc_pos[CSEL_W-1:0]];
        end else if (cnt_q == CRC_END) begin
          out_q <= 1'b1;
        end else begin
          out_q  <= 1'b1;
          oe_q   <= 1'b0;
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign cmd_out = out_q;
  assign cmd_oe  = oe_q;
  assign busy    = busy_q;
  assign done    = done_q;
endmodule

// File: rtl/sd_cmd_serializer_chk.sv
module sd_cmd_serializer_chk #(
  parameter int FRAME_W = 48
) (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic cmd_out,
  input logic cmd_oe,
  input logic busy,
  input logic done
);
  logic [7:0] oe_ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                oe_ticks <= '0;
    else if (done)             oe_ticks <= '0;
    else if (bit_tick && cmd_oe) oe_ticks <= oe_ticks + 1'b1;
  end

  AST_RELEASED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_oe |-> cmd_out); // R7
  AST_OE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> busy); // R7
  AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_oe) |-> !cmd_out); // R2
  AST_MOVE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(cmd_out) && $stable(cmd_oe)); // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !cmd_oe); // R8
  AST_OE_WINDOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> oe_ticks == 8'(FRAME_W)); // R7
endmodule

bind sd_cmd_serializer sd_cmd_serializer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .cmd_out(cmd_out),
  .cmd_oe(cmd_oe), .busy(busy), .done(done)
);

// File: tb/sd_cmd_serializer_bench.sv
module sd_cmd_serializer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, raw_mode = 1'b0, wr_flag = 1'b0, rdback_flag = 1'b0, bit_tick = 1'b0;
  logic [5:0]  cmd_index = '0;
  logic [31:0] raw_arg = '0;
  logic [2:0]  func_num = '0;
  logic [16:0] reg_addr = '0;
  logic [7:0]  wr_data = '0;
  logic cmd_out, cmd_oe, busy, done;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sd_cmd_serializer u_sd_cmd_serializer (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] crc7(input logic [39:0] h);
    logic [6:0] c = '0;
    for (int i = 39; i >= 0; i--) begin
      logic f = c[6] ^ h[i];
      c = {c[5:0], 1'b0};
      if (f) c = c ^ 7'b0001001;
    end
    return c;
  endfunction

  function automatic logic [47:0] expect_frame(input logic rm, input logic [5:0] idx,
      input logic [31:0] ra, input logic w, input logic [2:0] fn, input logic rb,
      input logic [16:0] ad, input logic [7:0] dt);
    logic [31:0] arg;
    logic [39:0] h;
    arg = rm ? ra : {w, fn, rb, 1'b0, ad, 1'b0, dt};
    h = {2'b01, rm ? idx : 6'd52, arg};
    return {h, crc7(h), 1'b1};
  endfunction

  task automatic scramble();
    raw_mode = 1'($urandom); cmd_index = 6'($urandom); raw_arg = $urandom;
    wr_flag = 1'($urandom); func_num = 3'($urandom); rdback_flag = 1'($urandom);
    reg_addr = 17'($urandom); wr_data = 8'($urandom);
  endtask

  task automatic run_frame(input string req, input bit disturb);
    logic [47:0] exp, got;
    bit moved = 0;
    exp = expect_frame(raw_mode, cmd_index, raw_arg, wr_flag, func_num, rdback_flag, reg_addr, wr_data);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy && !cmd_oe && cmd_out, "R6 idle line before first tick", {cmd_oe, cmd_out}, 2'b01);
    for (int i = 0; i < 49; i++) begin
      int gap = 1 + int'($urandom % 3);
      for (int g = 0; g < gap; g++) begin
        logic po = cmd_out, pe = cmd_oe;
        if (disturb && i == 20 && g == 0) begin start = 1'b1; scramble(); end
        @(negedge clk) start = 1'b0;
        if (cmd_out !== po || cmd_oe !== pe) moved = 1;
      end
      bit_tick = 1'b1;
      @(negedge clk) bit_tick = 1'b0;
      if (i < 48) begin
        got[47-i] = cmd_out;
        if (!cmd_oe || done) moved = 1;
      end
    end
    chk(!moved, "R6/R7 line moved off tick or oe dropped", 0, 0);
    chk(got === exp, {req, " frame"}, got, exp);
    chk(done && !busy && !cmd_oe && cmd_out, "R8/R7 done and release",
        {done, busy, cmd_oe, cmd_out}, 4'b1001);
    @(negedge clk);
    chk(!done, "R8 done single cycle", done, 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(cmd_out && !cmd_oe && !busy && !done, "R1 reset state", {cmd_out, cmd_oe, busy, done}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_out && !cmd_oe && !busy && !done, "R1 after reset release", {cmd_out, cmd_oe, busy, done}, 4'b1000);
    // R5: index 0, zero argument ends in 0x95
    raw_mode = 1'b1; cmd_index = 6'd0; raw_arg = 32'd0;
    chk(expect_frame(1, 0, 0, 0, 0, 0, 0, 0) == 48'h400000000095, "R5 bench crc anchor",
        expect_frame(1, 0, 0, 0, 0, 0, 0, 0), 48'h400000000095);
    run_frame("R5 R4 zero command", 0);
    // R3: packed write, extreme fields
    raw_mode = 1'b0; cmd_index = 6'd17; wr_flag = 1'b1; func_num = 3'd7; rdback_flag = 1'b1;
    reg_addr = 17'h1FFFF; wr_data = 8'hFF;
    run_frame("R3 packed all ones", 0);
    wr_flag = 1'b0; func_num = 3'd1; rdback_flag = 1'b0; reg_addr = 17'h10000; wr_data = 8'h00;
    run_frame("R3 packed read", 0);
    // R4: raw, all ones
    raw_mode = 1'b1; cmd_index = 6'h3F; raw_arg = 32'hFFFF_FFFF;
    run_frame("R4 R2 raw all ones", 0);
    // R9 R10: start and field changes mid frame
    raw_mode = 1'b0; reg_addr = 17'h0ABCD; wr_data = 8'h5A;
    run_frame("R9 R10 disturbed packed", 1);
    for (int n = 0; n < 30; n++) begin
      scramble();
      run_frame(n[0] ? "R9 R10 random disturbed" : "R2 R3 R4 R5 random", n[0]);
      repeat (int'($urandom % 3)) @(negedge clk);
    end
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule